// File: doc/BRIEF.md
# Sequential VRAM Data Port

This block lets an 8-bit host reach a video memory far larger than its own address space through one data port. The host first places a starting location by writing a high address register and a low address register; from then on each read or write of the data port touches the next consecutive byte. The host never has to rewrite the address while it streams a run of bytes.

The lowest bits of the video address come from neither register. A small group counter supplies them. Writing the low address register clears this counter, so every starting point the host can set is aligned to a group. Each data port access advances the counter. When the counter wraps, it carries into the low register, and the low register carries into the high register. The full address is the concatenation {high, low, counter}. With a 3-bit counter it spans 512 KiB, and with a 2-bit counter it spans 256 KiB. The memory read path is taken to be combinational: the byte at the presented address is returned to the host in the same cycle.

Top module: `vram_seq_port`

## Requirements
- R1: After reset, the high register, the low register and the group counter are all zero, so `vram_addr` is 0.
- R2: A host write with `host_sel`=0 loads `host_wdata` into the top 8 address bits. The low register and the group counter keep their values.
- R3: A host write with `host_sel`=1 loads `host_wdata` into the 8 address bits just above the counter and clears the counter. The high register is unchanged.
- R4: A host write with `host_sel`=2 raises `vram_we` in that cycle, with `vram_wdata` equal to `host_wdata` at the current `vram_addr`. On the next cycle the address is one higher.
- R5: A host read with `host_sel`=2 returns `vram_rdata` of the current address on `host_rdata` in the same cycle. On the next cycle the address is one higher.
- R6: When the counter is at its maximum, an access carries into the low register. A low register at 0xFF carries into the high register. An access at the all-ones address wraps the address to 0.
- R7: A read and a write of the data port in the same cycle perform one write and advance the address by exactly one.
- R8: Reads with `host_sel`=0 or 1, and any access with `host_sel`=3, leave the address unchanged. For those selects `host_rdata` is 0.
- R9: `vram_we` is asserted only in a cycle with a host write to `host_sel`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 high, 1 low, 2 data, 3 unused |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned to the host |
| vram_addr | output | 16+CW | Video memory byte address |
| vram_we | output | 1 | Video memory write enable |
| vram_wdata | output | 8 | Video memory write byte |
| vram_rdata | input | 8 | Byte read from video memory at `vram_addr` |

## Verification
The bench builds two copies side by side, one with the 3-bit counter (512 KiB) and one with the 2-bit counter (256 KiB), and drives both with the same stimulus. The narrower counter wraps every four accesses. This brings group carries into the low register much more often and tests the 18-bit address boundary alongside the 19-bit one. Directed runs start from 0xFF/0xFF, so both widths reach the full wrap to zero within eight accesses.

// File: rtl/vport_pkg.sv
package vport_pkg;
  typedef enum logic [1:0] {
    SEL_HIGH = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } vport_sel_e;

  typedef struct packed {
    logic set_high;
    logic set_low;
    logic mem_write;
    logic advance;
    logic data_sel;
  } vport_cmd_t;
endpackage

// File: rtl/vport_decode.sv
module vport_decode
  import vport_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       rd,
  input  logic       wr,
  output vport_cmd_t cmd
);
  vport_sel_e s;
  assign s = vport_sel_e'(sel);

  always_comb begin
    cmd.set_high  = wr && (s == SEL_HIGH);
    cmd.set_low   = wr && (s == SEL_LOW);
    cmd.data_sel  = (s == SEL_DATA);
    cmd.mem_write = wr && cmd.data_sel;
    cmd.advance   = (rd || wr) && cmd.data_sel;
  end
endmodule

// File: rtl/vport_group_ctr.sv
module vport_group_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [CW-1:0] count,
  output logic          wrap
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  function automatic logic [CW-1:0] step(input logic [CW-1:0] v);
    return v + 1'b1;
  endfunction

  assign wrap = advance && (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (advance) count <= step(count);
  end
endmodule

// File: rtl/vport_field_reg.sv
module vport_field_reg #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] load_val,
  input  logic          bump,
  output logic [RW-1:0] value
);
  function automatic logic [RW-1:0] step(input logic [RW-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (bump) value <= step(value);
  end
endmodule

// File: rtl/vram_seq_port.sv
module vram_seq_port
  import vport_pkg::*;
#(
  parameter int CW = 3,
  parameter int RW = 8,
  localparam int AW = 2 * RW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [RW-1:0] host_wdata,
  output logic [RW-1:0] host_rdata,
  output logic [AW-1:0] vram_addr,
  output logic          vram_we,
  output logic [RW-1:0] vram_wdata,
  input  logic [RW-1:0] vram_rdata
);
  localparam logic [RW-1:0] FIELD_TOP = {RW{1'b1}};

  vport_cmd_t    cmd;
  logic [CW-1:0] grp_count;
  logic          grp_carry;
  logic          lo_carry;
  logic [RW-1:0] lo_val;
  logic [RW-1:0] hi_val;

  vport_decode u_dec (
    .sel (host_sel),
    .rd  (host_rd),
    .wr  (host_wr),
    .cmd (cmd)
  );

  vport_group_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cmd.set_low),
    .advance (cmd.advance),
    .count   (grp_count),
    .wrap    (grp_carry)
  );

  assign lo_carry = grp_carry && (lo_val == FIELD_TOP);

  vport_field_reg #(.RW(RW)) u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd.set_low),
    .load_val (host_wdata),
    .bump     (grp_carry),
    .value    (lo_val)
  );

  vport_field_reg #(.RW(RW)) u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd.set_high),
    .load_val (host_wdata),
    .bump     (lo_carry),
    .value    (hi_val)
  );

  assign vram_addr  = {hi_val, lo_val, grp_count};
  assign vram_we    = cmd.mem_write;
  assign vram_wdata = host_wdata;
  assign host_rdata = cmd.data_sel ? vram_rdata : '0;
endmodule

// File: rtl/vram_seq_port_chk.sv
module vram_seq_port_chk #(
  parameter int CW = 3,
  parameter int RW = 8,
  localparam int AW = 2 * RW + CW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    host_sel,
  input logic          host_rd,
  input logic          host_wr,
  input logic [RW-1:0] host_wdata,
  input logic [AW-1:0] vram_addr,
  input logic          vram_we,
  input logic          grp_carry,
  input logic          lo_carry
);
  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> vram_addr == '0);

  p_high_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd0 |=>
      vram_addr[AW-1:RW+CW] == $past(host_wdata) &&
      vram_addr[RW+CW-1:0] == $past(vram_addr[RW+CW-1:0]));

  p_low_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd1 |=>
      vram_addr[CW-1:0] == '0 &&
      vram_addr[RW+CW-1:CW] == $past(host_wdata) &&
      vram_addr[AW-1:RW+CW] == $past(vram_addr[AW-1:RW+CW]));

  // R4, R5, R7
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_wr) && host_sel == 2'd2 |=>
      vram_addr == AW'($past(vram_addr) + 1'b1));

  p_group_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_carry |=> vram_addr[CW-1:0] == '0 &&
      vram_addr[RW+CW-1:CW] == RW'($past(vram_addr[RW+CW-1:CW]) + 1'b1));

  p_full_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_carry |=> vram_addr[RW+CW-1:0] == '0);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel != 2'd3) && !(host_rd && host_sel == 2'd2) |=>
      $stable(vram_addr));

  p_we_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> host_wr && host_sel == 2'd2);
endmodule

bind vram_seq_port vram_seq_port_chk #(.CW(CW), .RW(RW)) u_chk (.*);

// File: tb/vram_seq_port_tb.sv
module vram_seq_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = 2'd3;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;

  logic [7:0]  rdata3, rdata2, vwd3, vwd2, mrd3, mrd2;
  logic [18:0] addr3;
  logic [17:0] addr2;
  logic        we3, we2;

  int unsigned checks = 0;
  int unsigned bad = 0;
  bit          finished = 1'b0;
  logic [31:0] model [2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory content is a fixed pattern of the address
  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ {a[15:8]} ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  assign mrd3 = pat({13'b0, addr3});
  assign mrd2 = pat({14'b0, addr2});

  vram_seq_port #(.CW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(rdata3),
    .vram_addr(addr3), .vram_we(we3), .vram_wdata(vwd3), .vram_rdata(mrd3)
  );

  vram_seq_port #(.CW(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(rdata2),
    .vram_addr(addr2), .vram_we(we2), .vram_wdata(vwd2), .vram_rdata(mrd2)
  );

  function automatic int cw_of(input int k);
    return (k == 0) ? 3 : 2;
  endfunction

  function automatic logic [31:0] next_addr(input logic [31:0] a, input int c,
      input logic [1:0] sel, input logic rd, input logic wr, input logic [7:0] d);
    logic [31:0] hmask;
    hmask = 32'hFF << (8 + c);
    if (wr && sel == 2'd0) return (a & ~hmask) | ({24'b0, d} << (8 + c));
    if (wr && sel == 2'd1) return (a & hmask) | ({24'b0, d} << c);
    if ((rd || wr) && sel == 2'd2) return (a + 1) & ((32'd1 << (16 + c)) - 1);
    return a;
  endfunction

  task automatic check(input string tag, input int k, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dut%0d %s: actual=%h expected=%h", tag, k, what, act, exp);
    end
  endtask

  task automatic look(input string tag);
    logic [31:0] a [2];
    logic        w [2];
    logic [7:0]  wd [2];
    logic [7:0]  hr [2];
    a[0] = {13'b0, addr3}; w[0] = we3; wd[0] = vwd3; hr[0] = rdata3;
    a[1] = {14'b0, addr2}; w[1] = we2; wd[1] = vwd2; hr[1] = rdata2;
    for (int k = 0; k < 2; k++) begin
      bit dsel;
      dsel = (host_sel == 2'd2);
      check(tag, k, "addr", a[k], model[k]);
      check((host_wr && dsel) ? tag : "R9", k, "we", {31'b0, w[k]}, {31'b0, host_wr && dsel});
      if (w[k]) check(tag, k, "wdata", {24'b0, wd[k]}, {24'b0, host_wdata});
      check(tag, k, "rdata", {24'b0, hr[k]}, dsel ? {24'b0, pat(model[k])} : 32'd0);
    end
  endtask

  task automatic op(input logic [1:0] sel, input logic rd, input logic wr,
                    input logic [7:0] d, input string tag);
    @(negedge clk);
    host_sel = sel; host_rd = rd; host_wr = wr; host_wdata = d;
    #1;
    look(tag);
    @(posedge clk);
    for (int k = 0; k < 2; k++) model[k] = next_addr(model[k], cw_of(k), sel, rd, wr, d);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    host_sel = 2'd3; host_rd = 1'b0; host_wr = 1'b0;
    #1;
    look(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int unsigned seed;
    model[0] = '0; model[1] = '0;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    idle_check("R1");
    @(negedge clk); rst_n = 1'b1;
    idle_check("R1");

    op(2'd0, 1'b0, 1'b1, 8'hA5, "R2");
    op(2'd1, 1'b0, 1'b1, 8'h3C, "R3");
    for (int i = 0; i < 9; i++) op(2'd2, 1'b0, 1'b1, 8'(i * 17), "R4");
    for (int i = 0; i < 5; i++) op(2'd2, 1'b1, 1'b0, 8'h00, "R5");
    op(2'd0, 1'b0, 1'b1, 8'h11, "R2");
    idle_check("R2");
    op(2'd2, 1'b1, 1'b1, 8'h77, "R7");
    idle_check("R7");
    op(2'd0, 1'b1, 1'b0, 8'h00, "R8");
    op(2'd1, 1'b1, 1'b0, 8'h00, "R8");
    op(2'd3, 1'b1, 1'b1, 8'hEE, "R8");
    idle_check("R8");

    op(2'd0, 1'b0, 1'b1, 8'hFF, "R2");
    op(2'd1, 1'b0, 1'b1, 8'hFF, "R3");
    for (int i = 0; i < 9; i++) op(2'd2, 1'b1, 1'b0, 8'h00, "R6");
    idle_check("R6");
    op(2'd1, 1'b0, 1'b1, 8'h7F, "R3");
    for (int i = 0; i < 10; i++) op(2'd2, 1'b0, 1'b1, 8'(i), "R6");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] s;
      logic       r, w;
      string      t;
      s = 2'($urandom);
      r = 1'($urandom);
      w = 1'($urandom);
      if ($urandom_range(3) != 0 && s != 2'd2) s = 2'd2;
      if (s == 2'd0 && w) t = "R2";
      else if (s == 2'd1 && w) t = "R3";
      else if (s == 2'd2 && r && w) t = "R7";
      else if (s == 2'd2 && w) t = "R4";
      else if (s == 2'd2 && r) t = "R5";
      else t = "R8";
      op(s, r, w, 8'($urandom), t);
    end
    idle_check("R6");
    summary();
  end
endmodule